// File: doc/BRIEF.md
# Three-Read Bypassing Register File

This block is the architectural register file of a small processor core. It keeps fifteen 64-bit words, written through a single synchronous port. Three read ports return data combinationally. Read index 15 has no storage behind it and always reads as zero.

Each read port checks whether a write is active in the same cycle with a matching index. If so, the port returns the incoming write data. The core can therefore consume a result in the cycle it is produced, with no separate bypass network outside the file.

The file's edges are plain register-file signals, with no valid/ready handshake. A read is a pure function of its index and the current state. A write lands on the next rising clock edge.

Top module: `regfile_bypass`

## Requirements
- R1: A synchronous active-high reset clears all fifteen stored words to zero. After reset, every index from 0 to 14 reads as zero until it is written.
- R2: When write enable is high, the word at the write index (0 to 14) takes the write data on the rising clock edge. It reads back with that value in the following cycles.
- R3: While write enable is low, no stored word changes, whatever the write index and write data are.
- R4: A read port whose index is 15 returns all zeros in every cycle.
- R5: The constant zero at index 15 wins over forwarding. A read of index 15 returns zero even while a write to index 15 is enabled in the same cycle.
- R6: A write addressed to index 15 leaves all fifteen stored words unchanged.
- R7: While write enable is high and a read index (0 to 14) equals the write index, that read port returns the write data of the same cycle, not the stored word.
- R8: The three read ports are independent. Any of them may address the same index in the same cycle, and ports with equal indices return equal data.
- R9: When reset and write enable are both high in one cycle, reset wins and the addressed word is zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of all stored words |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write index; 15 is discarded |
| wr_data | input | 64 | Write data |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_data | output | 64 | Read port 0 data |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_data | output | 64 | Read port 1 data |
| rd2_idx | input | 4 | Read port 2 index |
| rd2_data | output | 64 | Read port 2 data |

## Verification
The assertions assume that every input is a known value at each rising edge and that reset is held for at least one edge before checking starts. They also assume that the write inputs are stable around the edge, since the forwarding path is combinational from them to the outputs. The bench drives all inputs at the falling edge from a single task and always releases reset only after a full cycle. The random phase deliberately biases read indices toward the write index and toward 15, so that forwarding and the zero priority are exercised under legal, fully driven stimulus.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  // Default geometry of the core's register file.
  localparam int unsigned RF_DATA_W = 64;
  localparam int unsigned RF_IDX_W  = 4;
  localparam int unsigned RF_RD_N   = 3;
endpackage

// File: rtl/regfile_store.sv
// Storage array: one register per writable word, synchronous reset, single write port.
module regfile_store #(
  parameter int unsigned DATA_W = regfile_pkg::RF_DATA_W,
  parameter int unsigned IDX_W  = regfile_pkg::RF_IDX_W,
  localparam int unsigned DEPTH = (1 << IDX_W) - 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0] words
);
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(w));
    always_ff @(posedge clk) begin
      if (rst) begin
        words[w] <= '0;
      end else if (hit) begin
        words[w] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/regfile_rdport.sv
// One combinational read port: zero index first, then same-cycle bypass, then storage.
module regfile_rdport #(
  parameter int unsigned DATA_W = regfile_pkg::RF_DATA_W,
  parameter int unsigned IDX_W  = regfile_pkg::RF_IDX_W,
  localparam int unsigned DEPTH = (1 << IDX_W) - 1,
  localparam int unsigned SLOTS = 1 << IDX_W
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] words,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [DATA_W-1:0]            rd_data
);
  localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(DEPTH);

  logic [SLOTS-1:0][DATA_W-1:0] padded;
  logic [DATA_W-1:0]            stored;
  logic                         is_zero;
  logic                         bypass;

  for (genvar s = 0; s < SLOTS; s++) begin : g_pad
    if (s < DEPTH) begin : g_real
      assign padded[s] = words[s];
    end else begin : g_const
      assign padded[s] = '0;
    end
  end

  assign stored  = padded[rd_idx];
  assign is_zero = (rd_idx == ZERO_IDX);
  assign bypass  = wr_en && (wr_idx == rd_idx);

  always_comb begin
    if (is_zero) begin
      rd_data = '0;
    end else if (bypass) begin
      rd_data = wr_data;
    end else begin
      rd_data = stored;
    end
  end
endmodule

// File: rtl/regfile_bypass.sv
// Top: storage plus a generated bank of bypassing read ports.
module regfile_bypass #(
  parameter int unsigned DATA_W = regfile_pkg::RF_DATA_W,
  parameter int unsigned IDX_W  = regfile_pkg::RF_IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd1_data,
  input  logic [IDX_W-1:0]  rd2_idx,
  output logic [DATA_W-1:0] rd2_data
);
  localparam int unsigned DEPTH = (1 << IDX_W) - 1;
  localparam int unsigned RD_N  = regfile_pkg::RF_RD_N;

  logic [DEPTH-1:0][DATA_W-1:0] words;
  logic [RD_N-1:0][IDX_W-1:0]   rd_idx_v;
  logic [RD_N-1:0][DATA_W-1:0]  rd_data_v;

  assign rd_idx_v[0] = rd0_idx;
  assign rd_idx_v[1] = rd1_idx;
  assign rd_idx_v[2] = rd2_idx;
  assign rd0_data    = rd_data_v[0];
  assign rd1_data    = rd_data_v[1];
  assign rd2_data    = rd_data_v[2];

  regfile_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .words   (words)
  );

  for (genvar p = 0; p < RD_N; p++) begin : g_rd
    regfile_rdport #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_port (
      .words   (words),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx_v[p]),
      .rd_data (rd_data_v[p])
    );
  end
endmodule

// File: rtl/regfile_bypass_chk.sv
module regfile_bypass_chk #(
  parameter int unsigned DATA_W = regfile_pkg::RF_DATA_W,
  parameter int unsigned IDX_W  = regfile_pkg::RF_IDX_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  rd0_idx,
  input logic [DATA_W-1:0] rd0_data,
  input logic [IDX_W-1:0]  rd1_idx,
  input logic [DATA_W-1:0] rd1_data,
  input logic [IDX_W-1:0]  rd2_idx,
  input logic [DATA_W-1:0] rd2_data
);
  localparam logic [IDX_W-1:0] ZI = {IDX_W{1'b1}};

  AST_ZERO_RD0: assert property (@(posedge clk) disable iff (rst)
    rd0_idx == ZI |-> rd0_data == '0); // R4
  AST_ZERO_RD1: assert property (@(posedge clk) disable iff (rst)
    rd1_idx == ZI |-> rd1_data == '0); // R4
  AST_ZERO_OVER_FWD: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_idx == ZI && rd2_idx == ZI |-> rd2_data == '0); // R5
  AST_FWD_RD0: assert property (@(posedge clk) disable iff (rst)
    wr_en && rd0_idx == wr_idx && rd0_idx != ZI |-> rd0_data == wr_data); // R7
  AST_FWD_RD2: assert property (@(posedge clk) disable iff (rst)
    wr_en && rd2_idx == wr_idx && rd2_idx != ZI |-> rd2_data == wr_data); // R7
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) && !$past(rst) && $past(wr_idx) != ZI && rd1_idx == $past(wr_idx)
      && !(wr_en && wr_idx == rd1_idx) |-> rd1_data == $past(wr_data)); // R2
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && !(wr_en && wr_idx == rd0_idx) |-> rd0_data == '0); // R1
  AST_SAME_IDX_01: assert property (@(posedge clk) disable iff (rst)
    rd0_idx == rd1_idx |-> rd0_data == rd1_data); // R8
  AST_SAME_IDX_12: assert property (@(posedge clk) disable iff (rst)
    rd1_idx == rd2_idx |-> rd1_data == rd2_data); // R8
endmodule

bind regfile_bypass regfile_bypass_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
  .rd2_idx(rd2_idx), .rd2_data(rd2_data)
);

// File: tb/regfile_bypass_test.sv
module regfile_bypass_test;
  localparam int DW = 64;
  localparam int IW = 4;
  localparam int WD_CYCLES = 150000;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic [IW-1:0] rd0_idx, rd1_idx, rd2_idx;
  logic [DW-1:0] rd0_data, rd1_data, rd2_data;

  always #4 clk = ~clk;  // 125 MHz

  regfile_bypass uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .rd2_idx(rd2_idx), .rd2_data(rd2_data)
  );

  typedef struct {
    int            port;
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  item_t         sb[$];
  logic [DW-1:0] mdl [15];
  int            checks = 0;
  int            errors = 0;
  bit            done   = 0;

  function automatic logic [DW-1:0] expect_rd(input logic [IW-1:0] idx);
    if (idx == 4'd15) return '0;
    if (wr_en && wr_idx == idx) return wr_data;
    return mdl[idx];
  endfunction

  function automatic string tag_for(input logic [IW-1:0] idx, input string dflt);
    if (idx == 4'd15) return (wr_en && wr_idx == 4'd15) ? "R5" : "R4";
    if (wr_en && wr_idx == idx) return "R7";
    return dflt;
  endfunction

  function automatic logic [DW-1:0] actual(input int p);
    case (p)
      0: return rd0_data;
      1: return rd1_data;
      default: return rd2_data;
    endcase
  endfunction

  // Driver: applies one cycle of stimulus, queues expectations, advances the model.
  task automatic step(input logic r, input logic we, input logic [IW-1:0] wi,
                      input logic [DW-1:0] wd, input logic [IW-1:0] a,
                      input logic [IW-1:0] b, input logic [IW-1:0] c, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; wr_en = we; wr_idx = wi; wr_data = wd;
    rd0_idx = a; rd1_idx = b; rd2_idx = c;
    if (!r) begin
      it.port = 0; it.exp = expect_rd(a); it.tag = tag_for(a, tag); sb.push_back(it);
      it.port = 1; it.exp = expect_rd(b); it.tag = tag_for(b, tag); sb.push_back(it);
      it.port = 2; it.exp = expect_rd(c); it.tag = tag_for(c, tag); sb.push_back(it);
    end
    if (r) begin
      for (int i = 0; i < 15; i++) mdl[i] = '0;
    end else if (we && wi != 4'd15) begin
      mdl[wi] = wd;
    end
  endtask

  // Monitor: compares queued expectations against the outputs mid-cycle.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        it = sb.pop_front();
        checks++;
        if (actual(it.port) !== it.exp) begin
          errors++;
          $display("FAIL %s port%0d actual=%h expected=%h", it.tag, it.port,
                   actual(it.port), it.exp);
        end
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", WD_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] a, b, c, wi;
    logic          we;
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd0_idx = '0; rd1_idx = '0; rd2_idx = '0;
    for (int i = 0; i < 15; i++) mdl[i] = '0;
    step(1, 0, 0, 0, 0, 0, 0, "");
    step(1, 1, 3, 64'hDEAD, 3, 3, 3, "");
    // R1 / R9: everything zero after reset, including the word written during reset
    for (int i = 0; i < 15; i += 3)
      step(0, 0, 0, 0, IW'(i), IW'(i+1), IW'(i+2), "R1");
    step(0, 0, 0, 0, 3, 3, 3, "R9");
    // R2: fill every word, then read back
    for (int i = 0; i < 15; i++)
      step(0, 1, IW'(i), {32'hA5A5_0000 + 32'(i), 32'(i * 7 + 1)}, 14, 13, 12, "R2");
    for (int i = 0; i < 15; i += 3)
      step(0, 0, 0, 0, IW'(i), IW'(i+1), IW'(i+2), "R2");
    // R3: disabled write has no effect
    step(0, 0, 2, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 2, "R3");
    step(0, 0, 2, 0, 2, 2, 2, "R3");
    // R4 / R5: index 15 reads zero, even while written
    step(0, 0, 0, 0, 15, 15, 15, "R4");
    step(0, 1, 15, 64'h1234_5678_9ABC_DEF0, 15, 15, 15, "R5");
    // R6: nothing changed by the write to 15
    for (int i = 0; i < 15; i += 3)
      step(0, 0, 0, 0, IW'(i), IW'(i+1), IW'(i+2), "R6");
    // R7 / R8: forwarding on all ports at once, mixed ports
    step(0, 1, 5, 64'hCAFE_F00D_0000_0005, 5, 5, 5, "R7");
    step(0, 1, 6, 64'h0BAD_0000_0000_0006, 6, 5, 15, "R8");
    step(0, 0, 0, 0, 5, 6, 5, "R8");
    // R8: random traffic biased toward collisions
    for (int n = 0; n < 400; n++) begin
      we = 1'($urandom_range(0, 3) != 0);
      wi = IW'($urandom_range(0, 15));
      a = ($urandom_range(0, 3) == 0) ? wi : IW'($urandom_range(0, 15));
      b = ($urandom_range(0, 3) == 0) ? a  : IW'($urandom_range(0, 15));
      c = ($urandom_range(0, 5) == 0) ? 4'd15 : IW'($urandom_range(0, 15));
      step(0, we, wi, {$urandom, $urandom}, a, b, c, "R8");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    @(negedge clk);
    #4;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule